// File: doc/BRIEF.md
# Adaptive step-rate smoothing level selector

This block sits between a motion segment planner and a step-tick engine. For each segment it takes the raw timer cycle count between steps and the number of steps in the segment. It then produces the values the tick engine runs on. A slow segment has a long cycle count. For such a segment the block picks an oversampling level from 0 to 3, cuts the tick period by 2^level and raises the tick count by 2^level. Slow multi-axis moves are therefore traced with finer timing resolution, while the total duration of the segment stays the same.

The three level thresholds come from the clock frequency parameter at elaboration time. They are the clock divided by 10000, by 5000 and by 2500. The scaled period is clamped to 16 bits. Segments flow in on a valid/ready stream and leave on a second valid/ready stream after one register stage. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat holds steady and no new segment is accepted.

Top module: `smooth_level_sel`

## Requirements
- R1: A segment whose cycle count is at most CLK_HZ/10000 (1600 at the default 16 MHz) is given level 0. Its period equals the cycle count and its step count is unchanged.
- R2: A cycle count above CLK_HZ/10000 and at most CLK_HZ/5000 (3200) is given level 1.
- R3: A cycle count above CLK_HZ/5000 and at most CLK_HZ/2500 (6400) is given level 2.
- R4: A cycle count above CLK_HZ/2500 is given level 3, which is the maximum.
- R5: The output period is the input cycle count shifted right by the chosen level.
- R6: If the shifted cycle count is 65536 or more, the output period is 16'hFFFF.
- R7: The output step count is the input step count shifted left by the level and truncated to 16 bits. No overflow is flagged.
- R8: A segment accepted on an edge (in_valid and in_ready both high) appears on the outputs with out_valid high right after that edge.
- R9: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, out_valid stays high and out_level, out_period and out_steps keep their values.
- R10: While rst_n is low and right after it rises, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input segment valid |
| in_ready | output | 1 | Block can accept a segment |
| in_cycles | input | 32 | Timer cycles per step |
| in_steps | input | 16 | Step count of the segment |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_level | output | 2 | Chosen smoothing level |
| out_period | output | 16 | Saturated tick period |
| out_steps | output | 16 | Scaled tick count |

## Verification
The assertions assume that the upstream side keeps the segment fields stable only on the edge where the segment is accepted. They also assume out_ready is a plain level that can change every cycle. The mapping assertions take their reference from `$past` of the inputs on the accepting edge, so they place no limit on what the inputs do between beats. The stimulus drives every input on the falling edge. It sweeps each threshold from both sides, pushes the period across the 16-bit clamp, and holds out_ready low for several cycles while a second segment waits on the input.

// File: rtl/smooth_pkg.sv
package smooth_pkg;
  localparam int MAX_LEVEL = 3;
  localparam int LVL_W     = $clog2(MAX_LEVEL + 1);
  localparam int BASE_DIV  = 10000;

  typedef logic [LVL_W-1:0] level_t;

  // Threshold for level idx+1: clock divided by BASE_DIV halved idx times
  function automatic longint unsigned level_thr(longint unsigned clk_hz, int idx);
    return clk_hz / (BASE_DIV >> idx);
  endfunction
endpackage

// File: rtl/smooth_level_pick.sv
module smooth_level_pick
  import smooth_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd16_000_000,
  parameter int CYC_W = 32
) (
  input  logic [CYC_W-1:0] cycles,
  output level_t           level
);
  logic [MAX_LEVEL-1:0] above;

  // One comparator per threshold; thresholds rise with the index
  for (genvar g = 0; g < MAX_LEVEL; g++) begin : g_cmp
    localparam longint unsigned THR = level_thr(CLK_HZ, g);
    assign above[g] = 64'(cycles) > THR;
  end

  // Thresholds are ordered, so the count of exceeded ones is the highest level
  always_comb begin
    level = '0;
    for (int i = 0; i < MAX_LEVEL; i++) begin
      if (above[i]) level = level_t'(i + 1);
    end
  end
endmodule

// File: rtl/smooth_scale.sv
module smooth_scale
  import smooth_pkg::*;
#(
  parameter int CYC_W  = 32,
  parameter int STEP_W = 16,
  parameter int PER_W  = 16
) (
  input  logic [CYC_W-1:0]  cycles,
  input  logic [STEP_W-1:0] steps,
  input  level_t            level,
  output logic [PER_W-1:0]  period,
  output logic [STEP_W-1:0] steps_scaled
);
  logic [CYC_W-1:0] shifted;

  assign shifted      = cycles >> level;
  assign steps_scaled = steps << level;

  // Clamp to the slowest representable rate when the high part is nonzero
  always_comb begin
    if (|shifted[CYC_W-1:PER_W]) period = '1;
    else                         period = shifted[PER_W-1:0];
  end
endmodule

// File: rtl/smooth_level_sel.sv
module smooth_level_sel
  import smooth_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd16_000_000,
  parameter int CYC_W  = 32,
  parameter int STEP_W = 16,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CYC_W-1:0]  in_cycles,
  input  logic [STEP_W-1:0] in_steps,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LVL_W-1:0]  out_level,
  output logic [PER_W-1:0]  out_period,
  output logic [STEP_W-1:0] out_steps
);
  level_t             lvl_c;
  logic [PER_W-1:0]   per_c;
  logic [STEP_W-1:0]  stp_c;
  logic               take;

  smooth_level_pick #(.CLK_HZ(CLK_HZ), .CYC_W(CYC_W)) u_pick (
    .cycles (in_cycles),
    .level  (lvl_c)
  );

  smooth_scale #(.CYC_W(CYC_W), .STEP_W(STEP_W), .PER_W(PER_W)) u_scale (
    .cycles       (in_cycles),
    .steps        (in_steps),
    .level        (lvl_c),
    .period       (per_c),
    .steps_scaled (stp_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_level  <= '0;
      out_period <= '0;
      out_steps  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_level  <= lvl_c;
        out_period <= per_c;
        out_steps  <= stp_c;
      end
    end
  end
endmodule

// File: rtl/smooth_level_chk.sv
module smooth_level_chk
  import smooth_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd16_000_000,
  parameter int CYC_W  = 32,
  parameter int STEP_W = 16,
  parameter int PER_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CYC_W-1:0]  in_cycles,
  input logic [STEP_W-1:0] in_steps,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LVL_W-1:0]  out_level,
  input logic [PER_W-1:0]  out_period,
  input logic [STEP_W-1:0] out_steps
);
  localparam longint unsigned T1 = level_thr(CLK_HZ, 0);
  localparam longint unsigned T3 = level_thr(CLK_HZ, 2);

  p_reset_empty_r10: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_ready_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_level)
                                   && $stable(out_period) && $stable(out_steps)));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_level0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_level == '0) == (64'($past(in_cycles)) <= T1)));

  p_level3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_level == LVL_W'(MAX_LEVEL)) == (64'($past(in_cycles)) > T3)));

  p_period_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (out_period == ((($past(in_cycles) >> out_level) > CYC_W'({PER_W{1'b1}}))
                      ? {PER_W{1'b1}} : PER_W'($past(in_cycles) >> out_level))));

  p_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_steps == STEP_W'($past(in_steps) << out_level)));
endmodule

bind smooth_level_sel smooth_level_chk #(
  .CLK_HZ(CLK_HZ), .CYC_W(CYC_W), .STEP_W(STEP_W), .PER_W(PER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_cycles(in_cycles), .in_steps(in_steps), .out_valid(out_valid),
  .out_ready(out_ready), .out_level(out_level), .out_period(out_period),
  .out_steps(out_steps)
);

// File: tb/sim_smooth_level_sel.sv
`timescale 1ns/1ps
module sim_smooth_level_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_cycles = '0;
  logic [15:0] in_steps = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_level;
  logic [15:0] out_period;
  logic [15:0] out_steps;

  int n_cmp = 0;
  int n_bad = 0;
  int wd = 0;

  always #4 clk = ~clk;

  smooth_level_sel u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cycles(in_cycles), .in_steps(in_steps), .out_valid(out_valid),
    .out_ready(out_ready), .out_level(out_level), .out_period(out_period),
    .out_steps(out_steps)
  );

  // {cycles, steps, level, period, steps_out}
  typedef struct packed {
    logic [31:0] cyc; logic [15:0] stp; logic [1:0] lvl; logic [15:0] per; logic [15:0] so;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'd100,        16'd7,      2'd0, 16'd100,   16'd7},      // R1
    '{32'd1600,       16'd5,      2'd0, 16'd1600,  16'd5},      // R1 edge
    '{32'd1601,       16'd5,      2'd1, 16'd800,   16'd10},     // R2
    '{32'd3200,       16'd3,      2'd1, 16'd1600,  16'd6},      // R2 edge
    '{32'd3201,       16'd3,      2'd2, 16'd800,   16'd12},     // R3
    '{32'd6400,       16'd4,      2'd2, 16'd1600,  16'd16},     // R3 edge
    '{32'd6401,       16'd4,      2'd3, 16'd800,   16'd32},     // R4
    '{32'd524287,     16'd1,      2'd3, 16'hFFFF,  16'd8},      // R5 largest unclamped
    '{32'd524288,     16'd2,      2'd3, 16'hFFFF,  16'd16},     // R6 clamp
    '{32'hFFFF_FFFF,  16'h3000,   2'd3, 16'hFFFF,  16'h8000},   // R6 R7 truncation
    '{32'd65536,      16'h1234,   2'd3, 16'd8192,  16'h91A0},   // R5 R7
    '{32'd0,          16'd0,      2'd0, 16'd0,     16'd0}       // R1 zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", wd);
      summary();
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", out_valid, 0);
    chk("R10 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", out_valid, 0);

    // Table walk, R1..R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_cycles = VEC[i].cyc; in_steps = VEC[i].stp;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 out_valid", out_valid, 1);
      chk("R1-4 level", out_level, VEC[i].lvl);
      chk("R5 R6 period", out_period, VEC[i].per);
      chk("R7 steps", out_steps, VEC[i].so);
    end
    @(negedge clk);
    chk("R8 out_valid drops when idle", out_valid, 0);

    // R9: back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_cycles = 32'd2000; in_steps = 16'd9;   // level 1, 1000, 18
    @(negedge clk);
    chk("R9 first beat valid", out_valid, 1);
    chk("R9 in_ready low", in_ready, 0);
    in_cycles = 32'd7000; in_steps = 16'd2;                     // level 3, 875, 16
    repeat (3) @(negedge clk);
    chk("R9 held valid", out_valid, 1);
    chk("R9 held level", out_level, 1);
    chk("R9 held period", out_period, 1000);
    chk("R9 held steps", out_steps, 18);
    out_ready = 1'b1;
    #1;
    chk("R9 in_ready follows out_ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second beat level", out_level, 3);
    chk("R9 second beat period", out_period, 875);
    chk("R9 second beat steps", out_steps, 16);

    // R10: reset while a beat is pending
    out_ready = 1'b0;
    in_valid = 1'b1; in_cycles = 32'd50; in_steps = 16'd1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-run reset clears valid", out_valid, 0);
    chk("R10 mid-run reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule